// File: doc/BRIEF.md
# Double Data Rate Input Capture with Realignment

This block samples a group of input pins on both phases of a clock and hands the fabric one pair of bits per pin. The first bit of each pair is taken on the rising edge of the primary clock. The second bit is taken on the rising edge of a second clock, which is normally the primary clock inverted. A fabric that receives both bits of a pair on one clock can run all of its downstream logic on that single clock.

A mode input chooses between two ways of delivering the second-phase bit. In cascade mode, the second-phase sample is copied into a further register on the primary clock, so both outputs change only on primary edges. In bypass mode, the second-phase register drives the output directly, and that output stays in the second clock's domain. The pair-valid flag shows when the realigned output holds a real sample rather than a reset value.

Parameters set the number of lanes (`WIDTH`), whether the bypass path is built at all (`HAS_BYPASS`), and whether the valid flag is generated (`HAS_VALID`). Input buffers and delay lines belong outside the block.

Top module: `ddr_in_capture`

## Requirements
- R1: On each rising edge of `clk_pri` with `rst` low, `even_q` loads `pad_i`. The new value is visible after that edge.
- R2: On each rising edge of `clk_sec` with `rst` low, the second-phase register loads `pad_i`.
- R3: With `cascade_en` = 1, `odd_q` takes the second-phase register's value on the next rising edge of `clk_pri`.
- R4: With `cascade_en` = 1, `odd_q` does not change at rising edges of `clk_sec`.
- R5: With `cascade_en` = 0, `odd_q` is the second-phase register itself. It changes at the rising edges of `clk_sec`.
- R6: Pad bits alternate between the outputs. In cascade mode, after each primary edge, `even_q` holds the bit sampled at that edge and `odd_q` holds the bit sampled at the second-clock edge just before it.
- R7: `rst` is active high and synchronous. It clears `even_q`, the second-phase register, the cascade register and `pair_valid` to 0 at the next edge of each register's own clock.
- R8: `pair_valid` is 0 during reset. It goes to 1 at the first rising edge of `clk_pri` that follows a rising edge of `clk_sec` with `rst` low. It stays at 1 until the next reset.
- R9: `cascade_en` = 1 selects cascade mode and 0 selects bypass mode. It may change only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary capture clock; its rising edge takes the first-phase bit |
| clk_sec | input | 1 | Second capture clock, normally the inverse of `clk_pri` |
| rst | input | 1 | Active-high synchronous reset |
| cascade_en | input | 1 | 1 = realign the second-phase bit onto `clk_pri`, 0 = bypass |
| pad_i | input | WIDTH | Data from the input pins |
| even_q | output | WIDTH | First-phase sample, in the `clk_pri` domain |
| odd_q | output | WIDTH | Second-phase sample, realigned or bypassed |
| pair_valid | output | 1 | High once the output pair carries real samples |

## Verification
The bench samples the outputs just after each primary edge and again just after each second-clock edge. This catches an `odd_q` that moves at the wrong edge. A cascade path that leaks the raw second-phase register would move at the mid-cycle sample. A bypass path that was retimed by mistake would lag half a cycle. Pairing is checked against a model of the pad stream: a design that paired the even bit with the following odd bit, rather than the preceding one, would fail every pair. Reset is checked both at start-up and in the middle of a stream. The valid flag is watched across the release of reset, where a flag raised one edge too early would expose the reset value as data.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

   // Delivery mode for the second-phase sample
   typedef enum logic {
      MODE_BYPASS  = 1'b0,
      MODE_CASCADE = 1'b1
   } ddr_mode_e;

   // Lowest lane count the block accepts
   localparam int unsigned MIN_LANES = 1;

endpackage

// File: rtl/ddr_cap_phase.sv
// One capture register bank, clocked by whichever phase clock it is given.
module ddr_cap_phase #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam logic [WIDTH-1:0] CLEAR_VAL = '0;

   genvar g;
   generate
      for (g = 0; g < WIDTH; g++) begin : g_lane
         logic bit_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) bit_q <= CLEAR_VAL[g];
            else       bit_q <= d_i[g];
         end
         assign q_o[g] = bit_q;
      end
   endgenerate

   // R1 on the primary instance, R2 on the second-phase instance
   p_capture_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (q_o == $past(d_i)));

   p_reset_clear_r7: assert property (@(posedge clk_i)
      rst_i |=> (q_o == '0));

endmodule

// File: rtl/ddr_cap_retime.sv
// Cascade register on the primary clock plus the selection of the odd output.
module ddr_cap_retime #(
   parameter int unsigned WIDTH      = 1,
   parameter bit          HAS_BYPASS = 1'b1
) (
   input  logic                  clk_pri_i,
   input  logic                  rst_i,
   input  ddr_cap_pkg::ddr_mode_e mode_i,
   input  logic [WIDTH-1:0]      sec_d_i,
   output logic [WIDTH-1:0]      odd_o
);
   import ddr_cap_pkg::*;

   logic [WIDTH-1:0] cas_q;

   always_ff @(posedge clk_pri_i) begin
      if (rst_i) cas_q <= '0;
      else       cas_q <= sec_d_i;
   end

   generate
      if (HAS_BYPASS) begin : g_sel
         assign odd_o = (mode_i == MODE_CASCADE) ? cas_q : sec_d_i;
      end else begin : g_fixed
         assign odd_o = cas_q;
      end
   endgenerate

   p_cascade_r3: assert property (@(posedge clk_pri_i) disable iff (rst_i)
      ((mode_i == MODE_CASCADE) && !$past(rst_i)) |-> (odd_o == $past(sec_d_i)));

   p_cascade_clear_r7: assert property (@(posedge clk_pri_i)
      (rst_i && (mode_i == MODE_CASCADE)) |=> (odd_o == '0));

endmodule

// File: rtl/ddr_cap_valid.sv
// Pair-valid flag: waits until the second phase has captured once after reset.
module ddr_cap_valid #(
   parameter bit HAS_VALID = 1'b1
) (
   input  logic clk_pri_i,
   input  logic clk_sec_i,
   input  logic rst_i,
   output logic valid_o
);

   generate
      if (HAS_VALID) begin : g_flag
         logic sec_seen_q;
         logic valid_q;

         always_ff @(posedge clk_sec_i) begin
            if (rst_i) sec_seen_q <= 1'b0;
            else       sec_seen_q <= 1'b1;
         end

         always_ff @(posedge clk_pri_i) begin
            if (rst_i) valid_q <= 1'b0;
            else       valid_q <= sec_seen_q;
         end

         assign valid_o = valid_q;

         p_valid_clear_r8: assert property (@(posedge clk_pri_i)
            rst_i |=> !valid_o);

         p_valid_sticky_r8: assert property (@(posedge clk_pri_i) disable iff (rst_i)
            (valid_o && !$past(rst_i)) |=> valid_o);
      end else begin : g_none
         assign valid_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
   parameter int unsigned WIDTH      = 1,
   parameter bit          HAS_BYPASS = 1'b1,
   parameter bit          HAS_VALID  = 1'b1
) (
   input  logic             clk_pri,
   input  logic             clk_sec,
   input  logic             rst,
   input  logic             cascade_en,
   input  logic [WIDTH-1:0] pad_i,
   output logic [WIDTH-1:0] even_q,
   output logic [WIDTH-1:0] odd_q,
   output logic             pair_valid
);
   import ddr_cap_pkg::*;

   generate
      if (WIDTH < MIN_LANES) begin : g_bad_width
         $error("ddr_in_capture: WIDTH must be at least %0d", MIN_LANES);
      end
   endgenerate

   ddr_mode_e        mode;
   logic [WIDTH-1:0] sec_q;

   assign mode = cascade_en ? MODE_CASCADE : MODE_BYPASS;

   ddr_cap_phase #(.WIDTH(WIDTH)) u_rise (
      .clk_i (clk_pri),
      .rst_i (rst),
      .d_i   (pad_i),
      .q_o   (even_q)
   );

   ddr_cap_phase #(.WIDTH(WIDTH)) u_fall (
      .clk_i (clk_sec),
      .rst_i (rst),
      .d_i   (pad_i),
      .q_o   (sec_q)
   );

   ddr_cap_retime #(.WIDTH(WIDTH), .HAS_BYPASS(HAS_BYPASS)) u_retime (
      .clk_pri_i (clk_pri),
      .rst_i     (rst),
      .mode_i    (mode),
      .sec_d_i   (sec_q),
      .odd_o     (odd_q)
   );

   ddr_cap_valid #(.HAS_VALID(HAS_VALID)) u_valid (
      .clk_pri_i (clk_pri),
      .clk_sec_i (clk_sec),
      .rst_i     (rst),
      .valid_o   (pair_valid)
   );

   p_mode_hold_r9: assert property (@(posedge clk_pri) disable iff (rst)
      !$past(rst) |-> $stable(cascade_en));

endmodule

// File: tb/ddr_in_capture_tb_top.sv
module ddr_in_capture_tb_top;

   localparam int  CLK_PERIOD = 10;
   localparam int  W          = 2;

   logic         clk_pri = 1'b0;
   logic         clk_sec;
   logic         rst = 1'b1;
   logic         cascade_en = 1'b1;
   logic [W-1:0] pad_i = '0;
   logic [W-1:0] even_q, odd_q;
   logic         pair_valid;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk_pri = ~clk_pri;
   assign clk_sec = ~clk_pri;

   ddr_in_capture #(.WIDTH(W)) dut_i (
      .clk_pri    (clk_pri),
      .clk_sec    (clk_sec),
      .rst        (rst),
      .cascade_en (cascade_en),
      .pad_i      (pad_i),
      .even_q     (even_q),
      .odd_q      (odd_q),
      .pair_valid (pair_valid)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] pat(input int seed, input int idx);
      case (seed)
         0:       pat = idx[0] ? W'(2'b10) : W'(2'b01);
         1:       pat = '1;
         default: pat = W'((idx * 5 + 3) ^ (idx >> 2));
      endcase
   endfunction

   // Hold reset with the chosen mode, check cleared state, release mid-cycle.
   task automatic do_reset(input logic mode);
      @(posedge clk_pri); #2;
      rst = 1'b1;
      cascade_en = mode;   // R9: mode changes only under reset
      pad_i = '1;
      repeat (3) @(posedge clk_pri);
      #1;
      chk("R7 even_q cleared", 8'(even_q), 8'h00);
      chk("R7 odd_q cleared", 8'(odd_q), 8'h00);
      chk("R8 valid low in reset", 8'(pair_valid), 8'h00);
   endtask

   // Stream n pairs in the given mode and check both outputs at both phases.
   task automatic t_stream(input logic mode, input int seed, input int n);
      logic [W-1:0] e_k, f_prev, f_k;
      do_reset(mode);
      #1;
      rst = 1'b0;
      f_k = pat(seed, 1);
      pad_i = f_k;
      @(posedge clk_sec); #1;
      chk("R8 valid still low before first primary edge", 8'(pair_valid), 8'h00);
      if (mode) chk("R4 cascade odd_q holds at second edge", 8'(odd_q), 8'h00);
      else      chk("R2 R5 bypass odd_q takes second-phase sample", 8'(odd_q), 8'(f_k));
      #1;
      e_k = pat(seed, 2);
      pad_i = e_k;
      for (int k = 1; k <= n; k++) begin
         f_prev = f_k;
         @(posedge clk_pri); #1;
         chk("R1 even_q after primary edge", 8'(even_q), 8'(e_k));
         if (mode) chk("R3 R6 cascade odd_q is preceding second-phase bit", 8'(odd_q), 8'(f_prev));
         else      chk("R5 bypass odd_q unchanged at primary edge", 8'(odd_q), 8'(f_prev));
         chk("R8 valid high", 8'(pair_valid), 8'h01);
         #1;
         f_k = pat(seed, 2 * k + 1);
         pad_i = f_k;
         @(posedge clk_sec); #1;
         chk("R1 even_q stable at second edge", 8'(even_q), 8'(e_k));
         if (mode) chk("R4 cascade odd_q quiet at second edge", 8'(odd_q), 8'(f_prev));
         else      chk("R2 R5 bypass odd_q at second edge", 8'(odd_q), 8'(f_k));
         #1;
         e_k = pat(seed, 2 * k + 2);
         pad_i = e_k;
      end
   endtask

   // Reset asserted in the middle of a cascade stream clears the pair.
   task automatic t_reset_midstream();
      t_stream(1'b1, 2, 4);
      @(posedge clk_pri); #2;
      rst = 1'b1;
      @(posedge clk_pri); #1;
      chk("R7 even_q cleared midstream", 8'(even_q), 8'h00);
      chk("R7 cascade odd_q cleared midstream", 8'(odd_q), 8'h00);
      chk("R8 valid dropped on reset", 8'(pair_valid), 8'h00);
      @(posedge clk_sec); #1;
      chk("R7 odd_q still clear after second edge", 8'(odd_q), 8'h00);
   endtask

   initial begin
      t_stream(1'b1, 0, 6);   // cascade, alternating lanes
      t_stream(1'b1, 1, 3);   // cascade, all ones
      t_stream(1'b0, 2, 6);   // bypass, mixed pattern (R9 mode select)
      t_stream(1'b0, 0, 3);   // bypass, alternating lanes
      t_reset_midstream();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule